// File: doc/BRIEF.md
# Triggered Dual-Lane Byte Pattern Streamer

This block plays a pre-loaded waveform out of two 8-bit output lanes once an external trigger arrives. The first lane drives a parallel DAC and has its own sample clock. The second lane drives eight control lines at the same rate but has no clock. Each lane takes 32-bit words from its own valid/ready stream and sends each word out as four bytes.

After reset or a synchronous re-arm, the DAC lane runs a short pre-arm pattern: its sample clock is low, then high, then low. Both lanes then wait with all-zero outputs. An internal detector waits for the trigger to be low and then high. That event releases both lanes in the same cycle, and from then on they stream without end at four core cycles per byte.

Back-pressure works as follows. A lane raises its ready only in a cycle where it needs a new word: the release cycle, the last cycle of its current word, or any cycle in which it is starved. A word is taken when valid and ready are both high. Valid may be low at any time. If valid is low when a word is needed, the lane stalls and its underflow flag is set.

Top module: `trig_pattern_streamer`

## Requirements
- R1: After reset or re-arm, both data lanes output 0x00 until the first byte of a stream appears.
- R2: After reset or re-arm, `dac_clk` is low for one cycle and then high for one cycle. It then stays low while the lanes wait for the trigger.
- R3: A start event happens only when the detector sees `trig_in` low and later high, and only while both lanes are waiting. A trigger that is already high when the lanes arm does not count.
- R4: `trig_dbg` is high for exactly one cycle for each start event and is low at all other times.
- R5: Both lanes present byte 0 of their first word in the cycle that follows the `trig_dbg` pulse.
- R6: Each word leaves as four bytes, least-significant byte first. Word bits [7:0] come first and bits [31:24] come last.
- R7: Each byte is held for four cycles. `dac_clk` is low in the first two of those cycles and high in the last two. The data never changes while `dac_clk` is high.
- R8: The control lane follows the same byte timing as the DAC lane and changes byte in the same cycle.
- R9: A lane's ready is high only in the release cycle, in the last cycle of a word, or while it is starved. When a word is available, the next word starts with no gap cycle.
- R10: If a lane needs a word and its valid is low, that lane holds its last byte with `dac_clk` low. Its `underflow` bit is then set (bit 0 for the DAC lane, bit 1 for the control lane). The bit stays set until `uf_clr` is applied in a cycle with no new underflow.
- R11: Trigger edges that arrive after the start event do not produce a new `trig_dbg` pulse and do not disturb the stream.
- R12: `arm` returns both lanes to the zero-output pre-arm sequence on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Synchronous return to the pre-trigger state |
| trig_in | input | 1 | External trigger, synchronous to `clk` |
| uf_clr | input | 1 | Clears the underflow flags |
| dac_word | input | 32 | DAC lane word |
| dac_valid | input | 1 | DAC lane word valid |
| dac_ready | output | 1 | DAC lane takes a word |
| ctl_word | input | 32 | Control lane word |
| ctl_valid | input | 1 | Control lane word valid |
| ctl_ready | output | 1 | Control lane takes a word |
| dac_data | output | 8 | DAC data byte |
| dac_clk | output | 1 | DAC sample clock; the DAC samples on its rising edge |
| ctl_data | output | 8 | Control line byte |
| trig_dbg | output | 1 | High for one cycle at the start event |
| underflow | output | 2 | Sticky starvation flags: bit 0 DAC lane, bit 1 control lane |

## Verification
The bench holds the trigger high while the lanes arm. A detector that looked at levels instead of the low-then-high sequence would start at once. The bench drains both streams so that a word boundary meets an empty input. A lane with a gap or an early ready would fall out of step with the model, and a lane that failed to hold its byte would show wrong bytes. It then toggles the trigger in mid-stream and re-arms during streaming. A detector that re-fires would restart the lanes, and an incomplete re-arm would leave old bytes or skip the clock-high pre-arm cycle.

// File: rtl/strm_pkg.sv
package strm_pkg;
  typedef enum logic [1:0] {LN_PRE_LO, LN_PRE_HI, LN_WAIT, LN_RUN} lane_st_t;
  typedef enum logic [1:0] {TD_SEEK_LO, TD_SEEK_HI, TD_SPENT} det_st_t;
endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect
  import strm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic enable_i,
  input  logic trig_i,
  output logic start_o
);
  det_st_t st;

  always_ff @(posedge clk) begin
    if (!rst_n || arm_i) begin
      st      <= TD_SEEK_LO;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      case (st)
        TD_SEEK_LO: if (enable_i && !trig_i) st <= TD_SEEK_HI;
        TD_SEEK_HI: if (trig_i) begin
          st      <= TD_SPENT;
          start_o <= 1'b1;
        end
        default: st <= TD_SPENT;
      endcase
    end
  end

  // R4: the start pulse lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  // R3: a start follows a cycle with the trigger high
  a_r3_high_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(trig_i));
  // R11: once spent, no further start until re-arm
  a_r11_spent_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TD_SPENT && !arm_i) |=> !start_o);
endmodule

// File: rtl/byte_lane.sv
module byte_lane
  import strm_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int CYC     = 4,
  parameter bit HAS_CLK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              uf_clr_i,
  output logic              uf_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              sclk_o,
  output logic              waiting_o
);
  localparam int NB   = WORD_W / BYTE_W;
  localparam int BIW  = (NB > 1) ? $clog2(NB) : 1;
  localparam int PHW  = (CYC > 1) ? $clog2(CYC) : 1;
  localparam int HALF = CYC / 2;
  localparam lane_st_t INIT = HAS_CLK ? LN_PRE_LO : LN_WAIT;

  lane_st_t          st;
  logic              stall;
  logic [PHW-1:0]    ph;
  logic [BIW-1:0]    bi;
  logic [WORD_W-1:0] word_q;
  logic              last_cyc;
  logic              need;

  assign last_cyc = (ph == PHW'(CYC - 1)) && (bi == BIW'(NB - 1));
  assign need     = !arm_i && ((st == LN_WAIT && start_i) ||
                               (st == LN_RUN && (stall || last_cyc)));
  assign ready_o  = need;

  always_ff @(posedge clk) begin
    if (!rst_n || arm_i) begin
      st     <= INIT;
      stall  <= 1'b0;
      ph     <= '0;
      bi     <= '0;
      word_q <= '0;
    end else if (need) begin
      st <= LN_RUN;
      if (valid_i) begin
        word_q <= word_i;
        ph     <= '0;
        bi     <= '0;
        stall  <= 1'b0;
      end else begin
        stall  <= 1'b1;
      end
    end else begin
      case (st)
        LN_PRE_LO: st <= LN_PRE_HI;
        LN_PRE_HI: st <= LN_WAIT;
        LN_RUN: if (!stall) begin
          if (ph == PHW'(CYC - 1)) begin
            ph <= '0;
            bi <= bi + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                uf_o <= 1'b0;
    else if (need && !valid_i) uf_o <= 1'b1;
    else if (uf_clr_i)         uf_o <= 1'b0;
  end

  assign data_o    = word_q[32'(bi) * BYTE_W +: BYTE_W];
  assign waiting_o = (st == LN_WAIT);

  generate
    if (HAS_CLK) begin : g_clk
      assign sclk_o = (st == LN_PRE_HI) ||
                      (st == LN_RUN && !stall && 32'(ph) >= HALF);
    end else begin : g_noclk
      assign sclk_o = 1'b0;
    end
  endgenerate

  // R7: data never moves while the sample clock is high
  a_r7_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_o) |-> !sclk_o);
  // R10: a stalled lane holds its byte
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> $stable(data_o));
  // R10: starvation raises the flag
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !valid_i) |=> uf_o);
  // R6 / R9: an accepted word shows its low byte next cycle
  a_r9_accept_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && valid_i) |=> (data_o == $past(word_i[BYTE_W-1:0])));
endmodule

// File: rtl/trig_pattern_streamer.sv
module trig_pattern_streamer
  import strm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              trig_in,
  input  logic              uf_clr,
  input  logic [WORD_W-1:0] dac_word,
  input  logic              dac_valid,
  output logic              dac_ready,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic              ctl_valid,
  output logic              ctl_ready,
  output logic [BYTE_W-1:0] dac_data,
  output logic              dac_clk,
  output logic [BYTE_W-1:0] ctl_data,
  output logic              trig_dbg,
  output logic [1:0]        underflow
);
  logic start;
  logic dac_wait, ctl_wait;
  logic ctl_sclk_unused;

  trig_edge_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm),
    .enable_i (dac_wait && ctl_wait),
    .trig_i   (trig_in),
    .start_o  (start)
  );

  byte_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CYC(CYC), .HAS_CLK(1'b1)) u_dac (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .start_i(start),
    .word_i(dac_word), .valid_i(dac_valid), .ready_o(dac_ready),
    .uf_clr_i(uf_clr), .uf_o(underflow[0]),
    .data_o(dac_data), .sclk_o(dac_clk), .waiting_o(dac_wait)
  );

  byte_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CYC(CYC), .HAS_CLK(1'b0)) u_ctl (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .start_i(start),
    .word_i(ctl_word), .valid_i(ctl_valid), .ready_o(ctl_ready),
    .uf_clr_i(uf_clr), .uf_o(underflow[1]),
    .data_o(ctl_data), .sclk_o(ctl_sclk_unused), .waiting_o(ctl_wait)
  );

  assign trig_dbg = start;

  // R5: both lanes ask for their first word in the release cycle
  a_r5_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !arm) |-> (dac_ready && ctl_ready));
endmodule

// File: tb/trig_pattern_streamer_tb.sv
module trig_pattern_streamer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, arm, trig_in, uf_clr;
  logic [31:0] dac_word, ctl_word;
  logic        dac_valid, ctl_valid, dac_ready, ctl_ready;
  logic [7:0]  dac_data, ctl_data;
  logic        dac_clk, trig_dbg;
  logic [1:0]  underflow;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trig_pattern_streamer u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_in(trig_in), .uf_clr(uf_clr),
    .dac_word(dac_word), .dac_valid(dac_valid), .dac_ready(dac_ready),
    .ctl_word(ctl_word), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .dac_data(dac_data), .dac_clk(dac_clk), .ctl_data(ctl_data),
    .trig_dbg(trig_dbg), .underflow(underflow)
  );

  int checks = 0, errors = 0;
  logic [31:0] dq[$], cq[$];
  bit trig_v = 1'b1, arm_v = 1'b0, clr_v = 1'b0;

  // behavioural reference: 0 pre-lo, 1 pre-hi, 2 wait, 3 run
  int          m_st[2], m_ph[2], m_bi[2];
  bit          m_stall[2], m_uf[2];
  logic [31:0] m_wd[2];
  int          m_det;
  bit          m_start;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int l = 0; l < 2; l++) begin
      m_st[l] = (l == 0) ? 0 : 2;
      m_ph[l] = 0; m_bi[l] = 0; m_stall[l] = 0; m_wd[l] = 0;
    end
    m_det = 0; m_start = 0;
  endfunction

  function automatic bit m_need(int l);
    return !arm_v && ((m_st[l] == 2 && m_start) ||
                      (m_st[l] == 3 && (m_stall[l] || (m_ph[l] == 3 && m_bi[l] == 3))));
  endfunction

  function automatic logic [7:0] m_byte(int l);
    return 8'((m_wd[l] >> (8 * m_bi[l])) & 32'hff);
  endfunction

  task automatic compare();
    logic exp_clk;
    exp_clk = (m_st[0] == 1) || (m_st[0] == 3 && !m_stall[0] && m_ph[0] >= 2);
    chk(dac_data == m_byte(0), (m_st[0] < 3) ? "R1" : "R6", dac_data, m_byte(0));
    chk(dac_clk == exp_clk, (m_st[0] < 3) ? "R2" : "R7", dac_clk, exp_clk);
    chk(ctl_data == m_byte(1), (m_st[1] < 3) ? "R1" : "R8", ctl_data, m_byte(1));
    chk(dac_ready == m_need(0), "R9", dac_ready, m_need(0));
    chk(ctl_ready == m_need(1), "R9", ctl_ready, m_need(1));
    chk(trig_dbg == m_start, "R4", trig_dbg, m_start);
    chk(underflow == {m_uf[1], m_uf[0]}, "R10", underflow, {m_uf[1], m_uf[0]});
  endtask

  task automatic advance();
    bit nd[2], vl[2], armed;
    logic [31:0] w[2];
    nd[0] = m_need(0); nd[1] = m_need(1);
    vl[0] = dac_valid; vl[1] = ctl_valid;
    w[0] = dac_word;   w[1] = ctl_word;
    armed = (m_st[0] == 2) && (m_st[1] == 2);
    for (int l = 0; l < 2; l++) begin
      if (nd[l] && !vl[l]) m_uf[l] = 1;
      else if (clr_v)      m_uf[l] = 0;
    end
    if (arm_v) begin
      model_reset();
    end else begin
      for (int l = 0; l < 2; l++) begin
        if (nd[l]) begin
          m_st[l] = 3;
          if (vl[l]) begin
            m_wd[l] = w[l]; m_bi[l] = 0; m_ph[l] = 0; m_stall[l] = 0;
          end else m_stall[l] = 1;
        end else if (m_st[l] == 0) m_st[l] = 1;
        else if (m_st[l] == 1) m_st[l] = 2;
        else if (m_st[l] == 3 && !m_stall[l]) begin
          if (m_ph[l] == 3) begin m_ph[l] = 0; m_bi[l] = m_bi[l] + 1; end
          else m_ph[l] = m_ph[l] + 1;
        end
      end
      m_start = 0;
      if (m_det == 0 && armed && !trig_v) m_det = 1;
      else if (m_det == 1 && trig_v) begin m_det = 2; m_start = 1; end
    end
    if (nd[0] && vl[0]) void'(dq.pop_front());
    if (nd[1] && vl[1]) void'(cq.pop_front());
  endtask

  // starts and ends at a falling edge
  task automatic step();
    dac_valid = (dq.size() > 0);
    dac_word  = dac_valid ? dq[0] : 32'h0;
    ctl_valid = (cq.size() > 0);
    ctl_word  = ctl_valid ? cq[0] : 32'h0;
    trig_in = trig_v; arm = arm_v; uf_clr = clr_v;
    #1;
    compare();
    advance();
    @(negedge clk);
  endtask

  task automatic load(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      dq.push_back(base + 32'h04040404 * i);
      cq.push_back(~(base + 32'h04040404 * i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; trig_in = 1'b1; uf_clr = 1'b0;
    dac_valid = 1'b0; ctl_valid = 1'b0; dac_word = '0; ctl_word = '0;
    m_uf[0] = 0; m_uf[1] = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R2 pre-arm clock pattern, trigger held high (R3)
    chk(dac_clk == 1'b0, "R2", dac_clk, 0);
    step();
    chk(dac_clk == 1'b1, "R2", dac_clk, 1);
    step();
    chk(dac_clk == 1'b0, "R2", dac_clk, 0);
    repeat (6) step();
    chk(trig_dbg == 1'b0, "R3", trig_dbg, 0);
    chk(dac_data == 8'h00 && ctl_data == 8'h00, "R1", {dac_data, ctl_data}, 0);

    // low then high starts both lanes
    load(3, 32'h04030201);
    trig_v = 1'b0; step();
    trig_v = 1'b1; step();
    chk(trig_dbg == 1'b1, "R4", trig_dbg, 1);
    step();
    chk(dac_data == 8'h01, "R5", dac_data, 8'h01);
    chk(ctl_data == 8'hfe, "R5", ctl_data, 8'hfe);

    // drain into underflow
    repeat (60) step();
    chk(underflow == 2'b11, "R10", underflow, 2'b11);
    chk(dac_data == 8'h0c && dac_clk == 1'b0, "R10", {dac_clk, dac_data}, 8'h0c);

    // refill, then clear the flags
    load(4, 32'h14131211);
    repeat (3) step();
    clr_v = 1'b1; step(); clr_v = 1'b0;
    chk(underflow == 2'b00, "R10", underflow, 0);

    // R11 mid-stream trigger edges
    for (int k = 0; k < 4; k++) begin
      trig_v = 1'b0; step();
      trig_v = 1'b1; step();
      chk(trig_dbg == 1'b0, "R11", trig_dbg, 0);
    end

    // R12 re-arm while streaming
    arm_v = 1'b1; step(); arm_v = 1'b0;
    chk(dac_data == 8'h00 && ctl_data == 8'h00 && dac_clk == 1'b0, "R12",
        {dac_clk, dac_data, ctl_data}, 0);
    step();
    chk(dac_clk == 1'b1, "R12", dac_clk, 1);
    dq.delete(); cq.delete();
    repeat (3) step();

    // second stream, lanes kept in lockstep
    load(6, 32'h24232221);
    trig_v = 1'b0; step();
    trig_v = 1'b1; step();
    repeat (100) step();
    chk(dac_clk == 1'b0 || dac_clk == 1'b1, "R8", dac_clk, dac_clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule